// File: doc/BRIEF.md
# Serial Transmit Queue with Refill Flag

This block is the sending side of an asynchronous serial port. Software pushes bytes into a sixteen-entry queue through a one-cycle write strobe. Whenever the line is free, a serializer takes the oldest byte and shifts it out as a frame: a low start bit, eight data bits starting with the least significant, and a high stop bit. It moves one bit for each pulse on a bit-tick input. When nothing is being sent, the line rests high.

A refill flag tells software that the queue has drained to a level it selects, so it can write a batch of bytes without checking each one. The flag is cleared with a clear strobe. The strobe only counts if software has first seen the flag high through a read strobe. If the queue is still at or below the chosen level when the clear arrives, the flag drops for one cycle and then comes straight back. The queue fill level is reported on a 16-bit count word, and a sticky bit records any write that arrived while the queue was full. A small override register lets software take the pin away from the serializer and hold it at a fixed level, which is how a line break is produced.

Top module: `uart_txq`

## Requirements
- R1: The queue holds 16 bytes. `tx_count[15:8]` shows the number of stored bytes and `tx_count[7:0]` is always zero.
- R2: A write while the queue holds 16 bytes is dropped and the count does not change. `tx_ovf` then rises one cycle later and stays high until reset.
- R3: The refill level is selected by `trig_sel`: 00 selects 8 bytes, 01 selects 4, 10 selects 2 and 11 selects 1. Whenever the count at a clock edge is at or below the level, `tx_empty_lvl` is 1 after that edge, unless a valid clear happens at the same edge.
- R4: A clear strobe is valid only if a read strobe was seen while `tx_empty_lvl` was 1, some time after the last valid clear. A valid clear drives `tx_empty_lvl` to 0 after the edge. An invalid clear has no effect.
- R5: A valid clear while the count is still at or below the level gives `tx_empty_lvl` = 0 for exactly one cycle, and the flag is 1 again after the next edge.
- R6: Each byte is sent as one frame. The frame is a 0 start bit, then data bits 0 through 7, then a 1 stop bit. Each bit holds until the next `bit_tick`. Bytes leave in the order they were written. A queued byte is loaded in the first cycle the serializer is idle.
- R7: When no frame is in progress and the override is off, `tx_pin` is 1.
- R8: `tx_end` is 1 exactly when the queue is empty and no frame is in progress.
- R9: A pulse on `ovr_we` loads `ovr_en_in` and `ovr_lvl_in` into the override register. While the stored enable is 1, `tx_pin` equals the stored level and the serializer keeps running underneath.
- R10: After reset: the count is 0, `tx_empty_lvl` = 1, `tx_end` = 1, `tx_ovf` = 0, `tx_pin` = 1, and the override is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to write |
| trig_sel | input | 2 | Refill level code |
| flag_rd | input | 1 | Software read of the refill flag |
| flag_clr | input | 1 | Clear strobe for the refill flag |
| bit_tick | input | 1 | One-cycle bit-period pulse |
| ovr_we | input | 1 | Load the override register |
| ovr_en_in | input | 1 | Override enable value to load |
| ovr_lvl_in | input | 1 | Override pin level to load |
| tx_pin | output | 1 | Serial line output |
| tx_empty_lvl | output | 1 | Refill flag |
| tx_end | output | 1 | Queue empty and line idle |
| tx_ovf | output | 1 | Sticky write-while-full flag |
| tx_count | output | 16 | Fill count in the upper byte |

## Verification
The assertions check on every cycle that:
- the count never goes above 16;
- a write into a full queue leaves the count alone and raises the sticky bit;
- the flag is set whenever the level condition holds and no valid clear is present;
- a valid clear lowers the flag;
- every frame begins with a low start bit and ends with a high stop bit;
- `tx_end` is never raised while bytes are waiting.

Some behaviour can only be shown by the bench scenarios, where a queue-based model follows the block cycle by cycle. This covers the bit order inside the frame, the order in which bytes leave, the one-cycle dip and return of the flag, and a clear that is ignored because no read came before it. It also covers a break held through the override while a frame runs underneath.

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    trig_sel,
  input  logic          flag_rd,
  input  logic          flag_clr,
  input  logic          bit_tick,
  input  logic          ovr_we,
  input  logic          ovr_en_in,
  input  logic          ovr_lvl_in,
  output logic          tx_pin,
  output logic          tx_empty_lvl,
  output logic          tx_end,
  output logic          tx_ovf,
  output logic [15:0]   tx_count
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int FRAME = DW + 2;
  localparam int NBW   = $clog2(FRAME);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    thresh;
  logic [FRAME-1:0] sh;
  logic [NBW-1:0]   nb;
  logic             busy, seen, ovr_en, ovr_lvl;
  logic             full, push, pop, lvl, clr_ok;

  assign full   = (cnt == CW'(DEPTH));
  assign push   = wr_en && !full;
  assign pop    = !busy && (cnt != '0);
  assign thresh = CW'(DEPTH / 2) >> trig_sel;
  assign lvl    = (cnt <= thresh);
  assign clr_ok = flag_clr && seen;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      tx_ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      if (wr_en && full) tx_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      nb   <= '0;
    end else if (pop) begin
      busy <= 1'b1;
      sh   <= {1'b1, mem[rp], 1'b0};
      nb   <= '0;
    end else if (busy && bit_tick) begin
      sh <= {1'b1, sh[FRAME-1:1]};
      if (nb == NBW'(FRAME - 1)) busy <= 1'b0;
      else nb <= nb + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty_lvl <= 1'b1;
      seen <= 1'b0;
    end else begin
      if (clr_ok)   tx_empty_lvl <= 1'b0;
      else if (lvl) tx_empty_lvl <= 1'b1;
      if (clr_ok) seen <= 1'b0;
      else if (flag_rd && tx_empty_lvl) seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_en  <= 1'b0;
      ovr_lvl <= 1'b1;
    end else if (ovr_we) begin
      ovr_en  <= ovr_en_in;
      ovr_lvl <= ovr_lvl_in;
    end
  end

  assign tx_pin   = ovr_en ? ovr_lvl : (busy ? sh[0] : 1'b1);
  assign tx_end   = !busy && (cnt == '0);
  assign tx_count = {{(8 - CW){1'b0}}, cnt, 8'h00};

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> tx_ovf && (cnt == $past(cnt) - CW'($past(pop))));

  // R2
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf);

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && !clr_ok) |=> tx_empty_lvl);

  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && seen) |=> !tx_empty_lvl);

  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && nb == '0 && !ovr_en) |-> !tx_pin);

  // R6
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && nb == NBW'(FRAME - 1) && !ovr_en) |-> tx_pin);

  // R8
  end_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> (tx_count == 16'h0000));
endmodule

// File: tb/uart_txq_tb_top.sv
module uart_txq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, flag_rd = 1'b0, flag_clr = 1'b0, bit_tick = 1'b0;
  logic ovr_we = 1'b0, ovr_en_in = 1'b0, ovr_lvl_in = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] trig_sel = 2'b00;
  logic tx_pin, tx_empty_lvl, tx_end, tx_ovf;
  logic [15:0] tx_count;

  int checks = 0, fails = 0, cyc = 0, tdiv = 0;

  always #5 clk = ~clk;

  uart_txq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .trig_sel(trig_sel), .flag_rd(flag_rd), .flag_clr(flag_clr),
    .bit_tick(bit_tick), .ovr_we(ovr_we), .ovr_en_in(ovr_en_in),
    .ovr_lvl_in(ovr_lvl_in), .tx_pin(tx_pin), .tx_empty_lvl(tx_empty_lvl),
    .tx_end(tx_end), .tx_ovf(tx_ovf), .tx_count(tx_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int q[$];
  bit m_busy, m_tde, m_seen, m_ovf, m_oen, m_olvl;
  int m_idx;
  bit [7:0] m_byte;

  always @(posedge clk) begin : model
    int oc, th;
    bit lvl_now, clr_now;
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_tde = 1; m_seen = 0; m_ovf = 0; m_oen = 0; m_olvl = 1; m_idx = 0;
    end else begin
      oc = q.size();
      th = 8 >> trig_sel;
      lvl_now = (oc <= th);
      clr_now = flag_clr && m_seen;
      if (!m_busy && oc > 0) begin
        m_byte = 8'(q.pop_front());
        m_busy = 1; m_idx = 0;
      end else if (m_busy && bit_tick) begin
        if (m_idx == 9) m_busy = 0; else m_idx++;
      end
      if (wr_en && oc < 16) q.push_back(int'(wr_data));
      if (wr_en && oc == 16) m_ovf = 1;
      if (clr_now) m_seen = 0;
      else if (flag_rd && m_tde) m_seen = 1;
      if (clr_now) m_tde = 0;
      else if (lvl_now) m_tde = 1;
      if (ovr_we) begin m_oen = ovr_en_in; m_olvl = ovr_lvl_in; end
    end
  end

  function automatic bit exp_pin();
    if (m_oen) return m_olvl;
    if (!m_busy) return 1'b1;
    if (m_idx == 0) return 1'b0;
    if (m_idx == 9) return 1'b1;
    return m_byte[m_idx - 1];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tx_pin == exp_pin(), "R6/R9 pin", int'(tx_pin), int'(exp_pin()));
      chk(tx_count == 16'(q.size() << 8), "R1 count", int'(tx_count), q.size() << 8);
      chk(tx_empty_lvl == m_tde, "R3 flag", int'(tx_empty_lvl), int'(m_tde));
      chk(tx_end == (!m_busy && q.size() == 0), "R8 end", int'(tx_end), int'(!m_busy && q.size() == 0));
      chk(tx_ovf == m_ovf, "R2 ovf", int'(tx_ovf), int'(m_ovf));
    end
    tdiv++;
    bit_tick = (tdiv % 4 == 0);
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_rd();
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic set_ovr(input logic en, input logic lv);
    ovr_we = 1'b1; ovr_en_in = en; ovr_lvl_in = lv;
    @(negedge clk);
    ovr_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(tx_pin == 1'b1, "R10 pin", int'(tx_pin), 1);
    chk(tx_count == 16'h0, "R10 count", int'(tx_count), 0);
    chk(tx_empty_lvl == 1'b1, "R10 flag", int'(tx_empty_lvl), 1);
    chk(tx_end == 1'b1, "R10 end", int'(tx_end), 1);
    chk(tx_ovf == 1'b0, "R10 ovf", int'(tx_ovf), 0);

    // R6 frames in order
    trig_sel = 2'b00;
    wr(8'hA5); wr(8'h3C); wr(8'h81);
    idle(200);
    // R7 idle line
    chk(tx_pin == 1'b1, "R7 idle", int'(tx_pin), 1);
    chk(tx_end == 1'b1, "R8 drained", int'(tx_end), 1);

    // R5 clear while still below level
    trig_sel = 2'b11;
    pulse_rd();
    pulse_clr();
    chk(tx_empty_lvl == 1'b0, "R5 dip", int'(tx_empty_lvl), 0);
    @(negedge clk);
    chk(tx_empty_lvl == 1'b1, "R5 return", int'(tx_empty_lvl), 1);

    // R4 clear without read ignored, with read honoured
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    pulse_clr();
    chk(tx_empty_lvl == 1'b1, "R4 no read", int'(tx_empty_lvl), 1);
    pulse_rd();
    pulse_clr();
    chk(tx_empty_lvl == 1'b0, "R4 cleared", int'(tx_empty_lvl), 0);
    @(negedge clk);
    chk(tx_empty_lvl == 1'b0, "R4 stays low", int'(tx_empty_lvl), 0);
    idle(250);

    // R2 overflow burst, R1 full count
    trig_sel = 2'b01;
    for (int i = 0; i < 20; i++) wr(8'(i * 17 + 3));
    chk(tx_ovf == 1'b1, "R2 ovf set", int'(tx_ovf), 1);
    chk(tx_count == 16'h1000, "R1 full", int'(tx_count), 16'h1000);
    idle(300);
    trig_sel = 2'b10;
    idle(500);

    // R9 break via override
    set_ovr(1'b1, 1'b0);
    chk(tx_pin == 1'b0, "R9 break", int'(tx_pin), 0);
    wr(8'hF0);
    idle(60);
    chk(tx_pin == 1'b0, "R9 held", int'(tx_pin), 0);
    set_ovr(1'b0, 1'b1);
    idle(100);
    chk(tx_ovf == 1'b1, "R2 sticky", int'(tx_ovf), 1);
    chk(tx_pin == 1'b1, "R7 after", int'(tx_pin), 1);
    finish_run();
  end
endmodule